// File: doc/BRIEF.md
# Dual Potentiometer Wiper and Preset Register Bank

This block holds the register state behind two digitally controlled potentiometers. Each channel has one volatile wiper register, which sets the active tap of the resistor array, and four preset registers that stand in for non-volatile storage. A serial front end decodes bus traffic into single-cycle commands. The block carries these commands out: direct writes and reads of either register kind, transfers between a preset and the wiper, and single-step moves of the wiper up or down.

For each channel the block drives a 256-wide one-hot tap-select vector to the switch array. Preset writes can be refused through an active-low protect pin. A refused write still completes its handshake and leaves a sticky flag. Two resets are kept apart. The power-on reset initialises everything, presets included. The ordinary logic reset leaves the presets alone and reloads each wiper from its preset 0, so a stored wiper setting is recalled.

Top module: `dual_pot_regbank`

## Requirements
- R1: Each of the two channels has one 8-bit wiper and four 8-bit presets. `cmd_ch` (0 or 1) selects the channel, and a command never changes the other channel's state.
- R2: Opcode encoding on `cmd_op`: 0 read wiper, 1 write wiper, 2 read preset, 3 write preset, 4 load preset into wiper, 5 save wiper into preset, 6 step up, 7 step down. A write takes `cmd_wdata`. A read returns its value on `rd_data` with `rd_vld` high in the cycle after the command.
- R3: Opcode 4 copies preset `cmd_reg` into the wiper. Opcode 5 copies the wiper into preset `cmd_reg`.
- R4: Step up at FFh leaves the wiper at FFh. Step down at 00h leaves it at 00h. Otherwise the wiper moves by one.
- R5: While `wp_n` is low, opcodes 3 and 5 leave every preset unchanged. Wiper writes and loads still take effect.
- R6: A refused preset write still raises `ack` and sets `prot_err`. The flag stays set until a read command (opcode 0 or 2) or a reset clears it.
- R7: `rst` reloads each wiper from that channel's preset 0 and keeps every preset as it was.
- R8: `por` sets every preset and every wiper to PRESET_INIT (80h by default).
- R9: Each channel's tap slice `tap_sel[c*256 +: 256]` has exactly one bit set, at the index equal to the wiper value (00h is the low end, FFh the high end). It follows a wiper change one cycle later.
- R10: `ack` is high for exactly the cycle that follows each accepted command, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous logic reset, active high; recalls wipers |
| por | input | 1 | Synchronous power-on reset, active high; initialises presets |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode |
| cmd_ch | input | 1 | Channel select |
| cmd_reg | input | 2 | Preset select |
| cmd_wdata | input | 8 | Write data |
| wp_n | input | 1 | Preset write protect, active low |
| ack | output | 1 | Command completed |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| prot_err | output | 1 | Sticky refused-write flag |
| tap_sel | output | 512 | One-hot tap selects, channel 0 in the low 256 bits |

## Verification
On every cycle the assertions check the structural rules: each channel's tap slice is one-hot and tracks the previous wiper value, the wiper saturates at FFh under step up, protected preset commands leave the presets stable, refusals set the flag, every command gets its `ack`, and a logic reset recalls preset 0. Only the bench scenarios can show the data paths end to end. These are the values returned by reads after writes, transfers and steps, the independence of the two channels, the flag clearing on a read, the presets surviving `rst` but not `por`, and the exact cycle at which the tap vector moves.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [2:0] {
    OP_RD_WIP = 3'd0,
    OP_WR_WIP = 3'd1,
    OP_RD_PRE = 3'd2,
    OP_WR_PRE = 3'd3,
    OP_LOAD   = 3'd4,
    OP_SAVE   = 3'd5,
    OP_UP     = 3'd6,
    OP_DOWN   = 3'd7
  } dpot_op_e;
endpackage

// File: rtl/dpot_channel.sv
module dpot_channel
  import dpot_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int INIT = 128,
  localparam int RB  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              sel,
  input  dpot_op_e          op,
  input  logic [RB-1:0]     regsel,
  input  logic [W-1:0]      wdata,
  input  logic              wp_n,
  output logic [W-1:0]      wip,
  output logic [NREG*W-1:0] presets,
  output logic              refused
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] INITV = W'(INIT);

  logic [W-1:0] dr [NREG];
  logic         pre_cmd, pre_wr;
  logic [W-1:0] pre_val;

  assign pre_cmd = sel && (op == OP_WR_PRE || op == OP_SAVE);
  assign pre_wr  = pre_cmd && wp_n;
  assign refused = pre_cmd && !wp_n;
  assign pre_val = (op == OP_SAVE) ? wip : wdata;

  // preset storage: only power-on reset touches it
  always_ff @(posedge clk) begin
    if (por) begin
      for (int i = 0; i < NREG; i++) dr[i] <= INITV;
    end else if (pre_wr) begin
      dr[regsel] <= pre_val;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      wip <= INITV;
    end else if (rst) begin
      wip <= dr[0];
    end else if (sel) begin
      case (op)
        OP_WR_WIP: wip <= wdata;
        OP_LOAD:   wip <= dr[regsel];
        OP_UP:     if (wip != MAXV) wip <= wip + 1'b1;
        OP_DOWN:   if (wip != '0) wip <= wip - 1'b1;
        default:   wip <= wip;
      endcase
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign presets[i*W +: W] = dr[i];
  end
endmodule

// File: rtl/dpot_tapdec.sv
module dpot_tapdec #(
  parameter int W    = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic [W-1:0]    wip,
  output logic [TAPS-1:0] tap
);
  always_ff @(posedge clk) begin
    tap      <= '0;
    tap[wip] <= 1'b1;
  end
endmodule

// File: rtl/dual_pot_regbank.sv
module dual_pot_regbank
  import dpot_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int NCH  = 2,
  parameter int PRESET_INIT = 128,
  localparam int RB   = $clog2(NREG),
  localparam int CB   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                por,
  input  logic                cmd_vld,
  input  logic [2:0]          cmd_op,
  input  logic [CB-1:0]       cmd_ch,
  input  logic [RB-1:0]       cmd_reg,
  input  logic [W-1:0]        cmd_wdata,
  input  logic                wp_n,
  output logic                ack,
  output logic                rd_vld,
  output logic [W-1:0]        rd_data,
  output logic                prot_err,
  output logic [NCH*TAPS-1:0] tap_sel
);
  dpot_op_e              op;
  logic [NCH*W-1:0]      wip_all;
  logic [NCH*NREG*W-1:0] pre_all;
  logic [NCH-1:0]        refused_all;
  logic                  is_read;

  assign op      = dpot_op_e'(cmd_op);
  assign is_read = cmd_vld && (op == OP_RD_WIP || op == OP_RD_PRE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dpot_channel #(.W(W), .NREG(NREG), .INIT(PRESET_INIT)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .por     (por),
      .sel     (cmd_vld && (cmd_ch == CB'(c))),
      .op      (op),
      .regsel  (cmd_reg),
      .wdata   (cmd_wdata),
      .wp_n    (wp_n),
      .wip     (wip_all[c*W +: W]),
      .presets (pre_all[c*NREG*W +: NREG*W]),
      .refused (refused_all[c])
    );
    dpot_tapdec #(.W(W)) u_dec (
      .clk (clk),
      .wip (wip_all[c*W +: W]),
      .tap (tap_sel[c*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      ack      <= 1'b0;
      rd_vld   <= 1'b0;
      rd_data  <= '0;
      prot_err <= 1'b0;
    end else begin
      ack    <= cmd_vld;
      rd_vld <= is_read;
      if (is_read) begin
        if (op == OP_RD_WIP)
          rd_data <= wip_all[int'(cmd_ch)*W +: W];
        else
          rd_data <= pre_all[(int'(cmd_ch)*NREG + int'(cmd_reg))*W +: W];
      end
      if (|refused_all)  prot_err <= 1'b1;
      else if (is_read)  prot_err <= 1'b0;
    end
  end
endmodule

// File: rtl/dpot_checker.sv
module dpot_checker #(
  parameter int W    = 8,
  parameter int NREG = 4,
  parameter int NCH  = 2,
  localparam int CB   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  por,
  input logic                  cmd_vld,
  input logic [2:0]            cmd_op,
  input logic [CB-1:0]         cmd_ch,
  input logic                  wp_n,
  input logic                  ack,
  input logic                  prot_err,
  input logic [NCH*TAPS-1:0]   tap_sel,
  input logic [NCH*W-1:0]      wip_all,
  input logic [NCH*NREG*W-1:0] pre_all
);
  logic por_seen = 1'b0;
  always_ff @(posedge clk) if (por) por_seen <= 1'b1;

  logic prot_cmd;
  assign prot_cmd = cmd_vld && !wp_n && (cmd_op == 3'd3 || cmd_op == 3'd5);

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst || por || !por_seen)
    cmd_vld |=> ack); // R10

  AST_PROT_SETS: assert property (@(posedge clk) disable iff (rst || por || !por_seen)
    prot_cmd |=> prot_err); // R6

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst || por || !por_seen)
      $onehot(tap_sel[c*TAPS +: TAPS])); // R9

    AST_TAP_TRACKS: assert property (@(posedge clk) disable iff (rst || por || !por_seen)
      tap_sel[c*TAPS +: TAPS] == (TAPS'(1) << $past(wip_all[c*W +: W]))); // R9

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst || por || !por_seen)
      (cmd_vld && cmd_ch == CB'(c) && cmd_op == 3'd6 && wip_all[c*W +: W] == {W{1'b1}})
      |=> wip_all[c*W +: W] == {W{1'b1}}); // R4

    AST_WP_HOLDS: assert property (@(posedge clk) disable iff (por || !por_seen)
      (prot_cmd && cmd_ch == CB'(c)) |=> $stable(pre_all[c*NREG*W +: NREG*W])); // R5

    AST_RECALL_DR0: assert property (@(posedge clk) disable iff (por || !por_seen)
      $past(rst) |-> wip_all[c*W +: W] == $past(pre_all[c*NREG*W +: W])); // R7
  end
endmodule

bind dual_pot_regbank dpot_checker #(.W(W), .NREG(NREG), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .por(por), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .cmd_ch(cmd_ch), .wp_n(wp_n), .ack(ack), .prot_err(prot_err),
  .tap_sel(tap_sel), .wip_all(wip_all), .pre_all(pre_all)
);

// File: tb/sim_dual_pot_regbank.sv
`timescale 1ns/1ps
module sim_dual_pot_regbank;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, por, cmd_vld, cmd_ch, wp_n;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_reg;
  logic [7:0]   cmd_wdata;
  logic         ack, rd_vld, prot_err;
  logic [7:0]   rd_data;
  logic [511:0] tap_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_pot_regbank u0 (
    .clk(clk), .rst(rst), .por(por), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data), .prot_err(prot_err),
    .tap_sel(tap_sel)
  );

  // fields: [27:24] req, [23:21] op, [20] ch, [19:18] preset, [17:10] wdata,
  //         [9] wp_n, [8:1] expected read, [0] check
  localparam int NV = 27;
  localparam logic [27:0] VEC [NV] = '{
    {4'd8, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h80, 1'b1}, // R8 wiper after por
    {4'd8, 3'd2, 1'b1, 2'd3, 8'h00, 1'b1, 8'h80, 1'b1}, // R8 preset after por
    {4'd2, 3'd1, 1'b0, 2'd0, 8'h05, 1'b1, 8'h00, 1'b0},
    {4'd2, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h05, 1'b1}, // R2
    {4'd2, 3'd3, 1'b1, 2'd2, 8'hA5, 1'b1, 8'h00, 1'b0},
    {4'd2, 3'd2, 1'b1, 2'd2, 8'h00, 1'b1, 8'hA5, 1'b1}, // R2
    {4'd5, 3'd3, 1'b1, 2'd2, 8'h11, 1'b0, 8'h00, 1'b0},
    {4'd5, 3'd2, 1'b1, 2'd2, 8'h00, 1'b1, 8'hA5, 1'b1}, // R5
    {4'd3, 3'd4, 1'b1, 2'd2, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd3, 3'd0, 1'b1, 2'd0, 8'h00, 1'b1, 8'hA5, 1'b1}, // R3 load
    {4'd1, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h05, 1'b1}, // R1 ch0 untouched
    {4'd3, 3'd5, 1'b0, 2'd3, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd3, 3'd2, 1'b0, 2'd3, 8'h00, 1'b1, 8'h05, 1'b1}, // R3 save
    {4'd5, 3'd1, 1'b0, 2'd0, 8'h06, 1'b0, 8'h00, 1'b0},
    {4'd5, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h06, 1'b1}, // R5 wiper write under protect
    {4'd5, 3'd5, 1'b0, 2'd3, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd5, 3'd2, 1'b0, 2'd3, 8'h00, 1'b1, 8'h05, 1'b1}, // R5 save refused
    {4'd4, 3'd6, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h07, 1'b1}, // R4 step up
    {4'd4, 3'd1, 1'b0, 2'd0, 8'hFF, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd6, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'hFF, 1'b1}, // R4 top saturate
    {4'd4, 3'd1, 1'b0, 2'd0, 8'h01, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd7, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd7, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd4, 3'd0, 1'b0, 2'd0, 8'h00, 1'b1, 8'h00, 1'b1}, // R4 bottom saturate
    {4'd1, 3'd2, 1'b1, 2'd0, 8'h00, 1'b1, 8'h80, 1'b1}  // R1 ch1 preset 0 untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on a falling edge; returns on the falling edge after the capturing edge
  task automatic do_cmd(input logic [2:0] op, input logic ch, input logic [1:0] rs,
                        input logic [7:0] wd, input logic wp);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_ch = ch; cmd_reg = rs; cmd_wdata = wd; wp_n = wp;
    @(negedge clk);
    cmd_vld = 1'b0; wp_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; por = 1'b1; cmd_vld = 1'b0; cmd_op = '0; cmd_ch = 1'b0;
    cmd_reg = '0; cmd_wdata = '0; wp_n = 1'b1;
    repeat (4) @(negedge clk);
    por = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R10 ack after reset", ack, 0);
    check("R6 prot_err after reset", prot_err, 0);
    check("R2 rd_vld after reset", rd_vld, 0);

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][23:21], VEC[i][20], VEC[i][19:18], VEC[i][17:10], VEC[i][9]);
      if (VEC[i][0]) begin
        check($sformatf("R%0d vector %0d rd_data", VEC[i][27:24], i), rd_data, VEC[i][8:1]);
        check($sformatf("R%0d vector %0d rd_vld", VEC[i][27:24], i), rd_vld, 1);
      end
    end

    // R9: ch0 wiper 00h, ch1 wiper A5h
    @(negedge clk);
    check("R9 ch0 tap at low end", tap_sel[255:0], 256'd1);
    check("R9 ch1 tap index A5h", tap_sel[511:256], 256'd1 << 8'hA5);
    do_cmd(3'd1, 1'b0, 2'd0, 8'h40, 1'b1);
    check("R10 ack one cycle after command", ack, 1);
    check("R9 tap not yet moved", tap_sel[255:0], 256'd1);
    @(negedge clk);
    check("R10 ack drops", ack, 0);
    check("R9 tap moved to 40h", tap_sel[255:0], 256'd1 << 8'h40);
    do_cmd(3'd1, 1'b0, 2'd0, 8'hFF, 1'b1);
    @(negedge clk);
    check("R9 tap at high end", tap_sel[255:0], 256'd1 << 255);

    // R6 sticky protect flag
    do_cmd(3'd3, 1'b0, 2'd1, 8'h22, 1'b0);
    check("R6 refused write acked", ack, 1);
    check("R6 flag set", prot_err, 1);
    repeat (3) @(negedge clk);
    check("R6 flag sticky", prot_err, 1);
    do_cmd(3'd2, 1'b0, 2'd1, 8'h00, 1'b1);
    check("R6 flag cleared by read", prot_err, 0);
    check("R5 preset 1 unchanged", rd_data, 8'h80);

    // R7 recall and preset retention over logic reset
    do_cmd(3'd3, 1'b0, 2'd0, 8'h37, 1'b1);
    do_cmd(3'd1, 1'b0, 2'd0, 8'h12, 1'b1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_cmd(3'd0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R7 ch0 wiper recalled", rd_data, 8'h37);
    do_cmd(3'd0, 1'b1, 2'd0, 8'h00, 1'b1);
    check("R7 ch1 wiper recalled", rd_data, 8'h80);
    do_cmd(3'd2, 1'b0, 2'd3, 8'h00, 1'b1);
    check("R7 preset survives rst", rd_data, 8'h05);

    // R8 power-on reset reinitialises presets
    por = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0;
    do_cmd(3'd2, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R8 preset 0 reinitialised", rd_data, 8'h80);
    do_cmd(3'd2, 1'b0, 2'd3, 8'h00, 1'b1);
    check("R8 preset 3 reinitialised", rd_data, 8'h80);
    do_cmd(3'd0, 1'b0, 2'd0, 8'h00, 1'b1);
    check("R8 wiper reinitialised", rd_data, 8'h80);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule